// File: doc/BRIEF.md
# Cascadable Four-Channel Interval Timer Group

This block holds four down-counting interval timers that share one clock prescaler and one group control register, all reached through a plain single-cycle register port. Software programs a reload value in each timer's base register and clears that register's stop bit to start the timer. From then on the timer produces a one-cycle interrupt pulse at a fixed interval, over and over, until the stop bit is set again. Each timer's current count can be read back, and software can overwrite it.

Neighbouring timers can be joined into a pair for intervals longer than one counter can reach. In a pair, the lower-numbered timer counts prescaled ticks. The higher-numbered timer counts one step each time the lower one wraps. Only the higher timer's interrupt output fires, and only its stop bit starts or halts the pair. The prescaler divides the block clock by 8, 16, 32 or 64, and all timers share that divided tick.

Register map (word index on `bus_addr`): 0 to 3 are the base registers of timers 0 to 3, 4 to 7 are their current-count registers, and 8 is the group control register. Any other index reads as zero and ignores writes.

Top module: `tmr_group`

## Requirements
- R1: After reset every base register reads 0x8000_0000 (stopped, reload 0), every count register reads 0, the group control register reads 0, and no interrupt is asserted.
- R2: Bit 31 of a base register is the stop bit. While the stop bit that governs a timer is set, that timer's count does not change and the timer raises no interrupt.
- R3: A write to a base register with bit 31 clear, made while that register's stop bit is set, copies bits 30:0 of the written value into the current count.
- R4: The prescaler field sits in bits 9:8 of the group control register: 00 divides by 8, 01 by 16, 10 by 32 and 11 by 64. A running timer with reload value N ≥ 1 pulses its interrupt every N×divisor clock cycles.
- R5: Every interrupt pulse is exactly one clock cycle wide.
- R6: A write to a count register loads bits 30:0 of the written value, so writing zero clears the count. Count registers read with bit 31 equal to 0.
- R7: Group control bits 0, 1 and 2 join timers 0+1, 1+2 and 2+3 into pairs. Bits 24, 25 and 26 are rollover enables paired with them. Only bits 2:0, 9:8 and 26:24 are stored; all other group control bits read 0.
- R8: In a pair, the higher timer steps only when the lower timer reloads. The pair's interrupt comes out on the higher timer every L×H prescaled ticks, where L and H are the two reload values.
- R9: A timer that is the lower half of a pair never asserts its own interrupt output. Its counting is governed by the higher timer's stop bit, not by its own.
- R10: A timer that is running but has not been written keeps its current count between reloads; it does not reset when other timers or the group register are written, apart from the prescaler change in R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 4 | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| tmr_irq | output | 4 | One-cycle interrupt pulse per timer |

## Verification
Single timers run with different reload values under each of the four prescaler settings. Because the interval is the product of the reload value and the divisor, a wrong divisor decode or an off-by-one in the reload shows up as a wrong spacing between pulses. A paired run with unequal low and high reload values checks the product L×H, and it also confirms that the lower timer stays silent, which separates a correct pairing from two timers running on their own. Register checks cover the reset values, stop-bit freezing of the count, clearing the count, and the unused control bits reading zero.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int NUM_TMR   = 4;
  localparam int DATA_W    = 32;
  localparam int CNT_W     = DATA_W - 1;
  localparam int ADDR_W    = 4;
  localparam int PRE_W     = 6;
  localparam int STOP_BIT  = DATA_W - 1;
  localparam int CASC_LSB  = 0;
  localparam int PRE_LSB   = 8;
  localparam int ROVR_LSB  = 24;
  localparam logic [ADDR_W-1:0] CTRL_IDX = ADDR_W'(2 * NUM_TMR);

  typedef struct packed {
    logic [NUM_TMR-2:0] rovr;
    logic [1:0]         pre;
    logic [NUM_TMR-2:0] casc;
  } grp_ctrl_t;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
  import tmr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] sel,
  output logic       tick
);
  logic [PRE_W-1:0] cnt_q, cnt_d;
  logic [PRE_W-1:0] limit;

  always_comb begin
    limit = PRE_W'((8 << sel) - 1);
    tick  = (cnt_q >= limit);
    cnt_d = tick ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R4: shortest divisor is 8, so ticks never come back to back
  a_r4_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic              run,
  input  logic              base_wr,
  input  logic              cnt_wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] base_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              rel_o
);
  logic [DATA_W-1:0] base_q, base_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              start_load;

  always_comb begin
    start_load = base_wr && base_q[STOP_BIT] && !wdata[STOP_BIT];
    rel_o      = step && run && (cnt_q <= CNT_W'(1));
    base_d     = base_wr ? wdata : base_q;
    cnt_d      = cnt_q;
    if (cnt_wr)                 cnt_d = wdata[CNT_W-1:0];
    else if (start_load)        cnt_d = wdata[CNT_W-1:0];
    else if (rel_o)             cnt_d = base_q[CNT_W-1:0];
    else if (step && run)       cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= {1'b1, {CNT_W{1'b0}}};
      cnt_q  <= '0;
    end else begin
      base_q <= base_d;
      cnt_q  <= cnt_d;
    end
  end

  assign base_o = base_q;
  assign cnt_o  = cnt_q;

  // R2: a halted timer with no writes keeps its count
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !cnt_wr && !base_wr) |=> $stable(cnt_o));
  // R8: a reload takes the programmed base value
  a_r8_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_o && !cnt_wr && !base_wr) |=> cnt_o == $past(base_o[CNT_W-1:0]));
  // R4: a step above one decrements by exactly one
  a_r4_decrement: assert property (@(posedge clk) disable iff (!rst_n)
    (step && run && cnt_o > CNT_W'(1) && !cnt_wr && !base_wr)
      |=> cnt_o == $past(cnt_o) - 1'b1);
endmodule

// File: rtl/tmr_group.sv
module tmr_group
  import tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NUM_TMR-1:0] tmr_irq
);
  grp_ctrl_t ctrl_q, ctrl_d;
  logic      tick;
  logic [NUM_TMR-1:0] step, run, rel, irq_d, irq_q;
  logic [NUM_TMR-1:0] base_wr, cnt_wr;
  logic [DATA_W-1:0]  base_v [NUM_TMR];
  logic [CNT_W-1:0]   cnt_v  [NUM_TMR];
  logic [DATA_W-1:0]  ctrl_word;

  tmr_prescaler u_pre (
    .clk  (clk),
    .rst_n(rst_n),
    .sel  (ctrl_q.pre),
    .tick (tick)
  );

  // stop control flows down from the top of each chain
  assign run[NUM_TMR-1] = !base_v[NUM_TMR-1][STOP_BIT];

  for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
    assign base_wr[i] = bus_wr && (bus_addr == ADDR_W'(i));
    assign cnt_wr[i]  = bus_wr && (bus_addr == ADDR_W'(NUM_TMR + i));

    if (i < NUM_TMR - 1) begin : g_run
      assign run[i] = ctrl_q.casc[i] ? run[i+1] : !base_v[i][STOP_BIT];
      assign irq_d[i] = rel[i] && !ctrl_q.casc[i];
    end else begin : g_top
      assign irq_d[i] = rel[i];
    end

    if (i == 0) begin : g_first
      assign step[i] = tick;
    end else begin : g_chain
      assign step[i] = ctrl_q.casc[i-1] ? rel[i-1] : tick;
    end

    tmr_channel u_ch (
      .clk    (clk),
      .rst_n  (rst_n),
      .step   (step[i]),
      .run    (run[i]),
      .base_wr(base_wr[i]),
      .cnt_wr (cnt_wr[i]),
      .wdata  (bus_wdata),
      .base_o (base_v[i]),
      .cnt_o  (cnt_v[i]),
      .rel_o  (rel[i])
    );

    // R5: interrupt pulses last a single cycle
    a_r5_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      tmr_irq[i] |=> !tmr_irq[i]);
  end

  always_comb begin
    ctrl_d = ctrl_q;
    if (bus_wr && bus_addr == CTRL_IDX) begin
      ctrl_d.casc = bus_wdata[CASC_LSB +: NUM_TMR-1];
      ctrl_d.pre  = bus_wdata[PRE_LSB +: 2];
      ctrl_d.rovr = bus_wdata[ROVR_LSB +: NUM_TMR-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      irq_q  <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      irq_q  <= irq_d;
    end
  end

  always_comb begin
    ctrl_word = '0;
    ctrl_word[CASC_LSB +: NUM_TMR-1] = ctrl_q.casc;
    ctrl_word[PRE_LSB +: 2]          = ctrl_q.pre;
    ctrl_word[ROVR_LSB +: NUM_TMR-1] = ctrl_q.rovr;
    bus_rdata = '0;
    if (bus_addr < ADDR_W'(NUM_TMR))
      bus_rdata = base_v[bus_addr[1:0]];
    else if (bus_addr < ADDR_W'(2 * NUM_TMR))
      bus_rdata = {1'b0, cnt_v[bus_addr[1:0]]};
    else if (bus_addr == CTRL_IDX)
      bus_rdata = ctrl_word;
  end

  assign tmr_irq = irq_q;

  // R9: the lower half of pair 0+1 stays silent
  a_r9_low_silent: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_irq[0] |-> !$past(ctrl_q.casc[0]));
  // R2: no interrupt from a halted top timer
  a_r2_halt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_irq[NUM_TMR-1] |-> $past(run[NUM_TMR-1]));
endmodule

// File: tb/tmr_group_test.sv
module tmr_group_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        bus_wr = 0;
  logic [3:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic [3:0]  tmr_irq;

  int n_chk = 0, n_fail = 0;
  int cyc = 0;
  int mon_ch = 0;
  bit have_prev = 0;
  int prev_cyc = 0;
  int exp_q[$];
  string exp_tag = "";
  int irq0_seen = 0;
  bit done = 0;

  always #5 clk = ~clk;

  tmr_group uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tmr_irq(tmr_irq)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // monitor: compares pulse spacing against the expected queue
  always @(negedge clk) begin
    cyc++;
    if (tmr_irq[0]) irq0_seen++;
    if (tmr_irq[mon_ch] && exp_q.size() > 0) begin
      if (have_prev) begin
        int e;
        e = exp_q.pop_front();
        check(exp_tag, cyc - prev_cyc, e);
      end
      prev_cyc  = cyc;
      have_prev = 1;
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd_check(string tag, input logic [3:0] a, input logic [31:0] exp);
    @(negedge clk);
    bus_addr = a;
    #1;
    check(tag, bus_rdata, exp);
  endtask

  // driver: queue expected periods and wait until the monitor consumes them
  task automatic expect_period(string tag, int ch, int per, int n);
    mon_ch = ch; have_prev = 0; exp_tag = tag;
    for (int k = 0; k < n; k++) exp_q.push_back(per);
    while (exp_q.size() > 0) @(negedge clk);
  endtask

  initial begin
    while (cyc < 150000 && !done) @(negedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] c1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd_check("R1 base0", 4'd0, 32'h8000_0000);
    rd_check("R1 base3", 4'd3, 32'h8000_0000);
    rd_check("R1 count2", 4'd6, 32'h0);
    rd_check("R1 ctrl", 4'd8, 32'h0);
    check("R1 irq", {28'h0, tmr_irq}, 32'h0);

    // R7 control field storage
    wr(4'd8, 32'hFFFF_FFFF);
    rd_check("R7 ctrl mask", 4'd8, 32'h0700_0307);
    wr(4'd8, 32'h0);

    // R3 start load, R4 div 8
    wr(4'd0, 32'd5);
    rd_check("R3 start load", 4'd4, 32'd5);
    expect_period("R4 div8 base5", 0, 40, 3);

    // R2 stop freezes count, R10 untouched count holds
    wr(4'd0, 32'h8000_0005);
    @(negedge clk); bus_addr = 4'd4; #1; c1 = bus_rdata;
    repeat (100) @(negedge clk);
    rd_check("R2 frozen count", 4'd4, c1);

    // R6 count write clears
    wr(4'd4, 32'h0);
    rd_check("R6 count cleared", 4'd4, 32'h0);
    wr(4'd4, 32'hFFFF_FFFF);
    rd_check("R6 bit31 reads 0", 4'd4, 32'h7FFF_FFFF);

    // R4 other divisors
    wr(4'd8, 32'h0000_0200);
    wr(4'd1, 32'd3);
    expect_period("R4 div32 base3", 1, 96, 2);
    wr(4'd1, 32'h8000_0003);
    wr(4'd8, 32'h0000_0300);
    wr(4'd2, 32'd2);
    expect_period("R4 div64 base2", 2, 128, 2);
    wr(4'd2, 32'h8000_0002);
    wr(4'd8, 32'h0000_0100);
    wr(4'd3, 32'd4);
    expect_period("R4 div16 base4", 3, 64, 2);
    wr(4'd3, 32'h8000_0004);
    rd_check("R10 timer3 stored base", 4'd3, 32'h8000_0004);

    // R8/R9 cascade 0+1: L=3 H=2 div 8 -> 48 cycles
    wr(4'd8, 32'h0100_0001);
    wr(4'd0, 32'h8000_0003);
    wr(4'd4, 32'd3);
    irq0_seen = 0;
    wr(4'd1, 32'd2);
    expect_period("R8 cascade L3 H2", 1, 48, 3);
    check("R9 low half silent", irq0_seen, 0);
    // R9 low half governed by high stop bit
    wr(4'd1, 32'h8000_0002);
    @(negedge clk); bus_addr = 4'd4; #1; c1 = bus_rdata;
    repeat (60) @(negedge clk);
    rd_check("R9 low stops with high", 4'd4, c1);

    // R8 cascade with different values: L=4 H=3 div16 -> 192
    wr(4'd8, 32'h0000_0101);
    wr(4'd4, 32'd4);
    wr(4'd0, 32'h8000_0004);
    wr(4'd1, 32'd3);
    expect_period("R8 cascade L4 H3", 1, 192, 2);
    wr(4'd1, 32'h8000_0003);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule